// File: doc/BRIEF.md
# Memory-Mapped Countdown Timer

A 32-bit down-counter behind a small word-addressed register bus. Software loads a period, then starts or halts the counter by writing command bits into a stored control word. The count advances only on cycles where the tick-enable input is high. When the count runs out, the block latches a timeout flag. It then either stops (one-shot) or reloads from the period and keeps going (continuous). A level interrupt follows the flag, gated by an enable bit in the control word.

Software clears the flag by writing anything to the status word. The live count can be read at any time through a read-only snapshot word. Writing the period also loads the counter at once, so a running timer can be retargeted without halting it. Only full 32-bit word accesses exist; reads are combinational from the address.

Top module: `cdown_timer`

## Requirements
- R1: After reset every register reads 0, the counter is halted and `irq` is low.
- R2: The word is chosen by address bits [3:2] (0 status, 1 control, 2 period, 3 snapshot), and bits [1:0] are ignored. Status bit 0 is the timeout flag and bit 1 is the running state. Control bit 0 is interrupt enable, bit 1 continuous, bit 2 start and bit 3 stop.
- R3: Any write to the status word clears the timeout flag, whatever the data written.
- R4: A control write stores the full 32-bit value. Start sets the counter running, stop halts it, and with both set the counter ends up halted.
- R5: A period write stores the value and loads it into the counter in the same cycle.
- R6: The snapshot word reads the live count. Writes to it change nothing.
- R7: While running, the count drops by one on each cycle with `tick_en` high. While halted, or with `tick_en` low, it holds.
- R8: Expiry is the running tick taken at a count of 1, or at 0. It sets the timeout flag. In one-shot mode the count becomes 0 and the counter halts.
- R9: In continuous mode an expiry reloads the count from the period and the counter keeps running.
- R10: `irq` is high exactly while the timeout flag and the interrupt enable bit are both set.
- R11: An expiry in the same cycle as a status write leaves the flag set.
- R12: Addresses with any bit above bit 3 set read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for this cycle |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land in the same cycle: a counter expiry and a software write to the status word. The bench runs a one-shot count down to 1, then raises `tick_en` and the status write on the same clock edge. It judges the result by reading the status word back: the flag must still be set, and a later plain status write must clear it. The period write racing a live countdown is also covered, by retargeting a running counter and reading the snapshot.

// File: rtl/cdown_timer_pkg.sv
package cdown_timer_pkg;
    typedef enum logic [1:0] {
        IDX_STATUS = 2'd0,
        IDX_CTRL   = 2'd1,
        IDX_PERIOD = 2'd2,
        IDX_SNAP   = 2'd3
    } reg_idx_e;

    localparam int CTL_IE   = 0;
    localparam int CTL_CONT = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_HALT = 3;

    typedef struct packed {
        logic status;
        logic ctrl;
        logic period;
    } wr_hit_t;

    function automatic logic runs_out(input logic [31:0] cnt);
        return cnt <= 32'd1;
    endfunction
endpackage

// File: rtl/cdown_timer_decode.sv
module cdown_timer_decode
    import cdown_timer_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              mapped,
    output reg_idx_e          idx,
    output wr_hit_t           hit
);
    logic unused_lsb;
    assign unused_lsb = ^bus_addr[1:0];

    generate
        if (ADDR_W > 4) begin : g_upper
            assign mapped = (bus_addr[ADDR_W-1:4] == '0);
        end else begin : g_flat
            assign mapped = 1'b1;
        end
    endgenerate

    assign idx = reg_idx_e'(bus_addr[3:2]);

    always_comb begin
        hit = '0;
        if (bus_wr && mapped) begin
            hit.status = (idx == IDX_STATUS);
            hit.ctrl   = (idx == IDX_CTRL);
            hit.period = (idx == IDX_PERIOD);
        end
    end
endmodule

// File: rtl/cdown_timer_regs.sv
module cdown_timer_regs
    import cdown_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_hit_t           hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] period_q,
    output logic              flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (hit.ctrl)   ctrl_q   <= wdata;
            if (hit.period) period_q <= wdata;
            if (expire)          flag_q <= 1'b1;
            else if (hit.status) flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cdown_timer_counter.sv
module cdown_timer_counter
    import cdown_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load,
    input  logic              cmd,
    input  logic              go,
    input  logic              halt,
    input  logic              cont,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] cnt_q,
    output logic              run_q,
    output logic              expire
);
    logic [DATA_W-1:0] cnt_d;
    logic              run_d;

    assign expire = run_q && tick_en && (cnt_q <= DATA_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load)               cnt_d = wdata;
        else if (expire)        cnt_d = cont ? period : '0;
        else if (run_q && tick_en) cnt_d = cnt_q - DATA_W'(1);
        if (expire && !cont) run_d = 1'b0;
        if (cmd && go)       run_d = 1'b1;
        if (cmd && halt)     run_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
    import cdown_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              mapped;
    reg_idx_e          idx;
    wr_hit_t           hit;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic              flag_q;
    logic [DATA_W-1:0] cnt_q;
    logic              run_q;
    logic              expire;

    cdown_timer_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .mapped   (mapped),
        .idx      (idx),
        .hit      (hit)
    );

    cdown_timer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .wdata    (bus_wdata),
        .expire   (expire),
        .ctrl_q   (ctrl_q),
        .period_q (period_q),
        .flag_q   (flag_q)
    );

    cdown_timer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (hit.period),
        .cmd      (hit.ctrl),
        .go       (bus_wdata[CTL_GO]),
        .halt     (bus_wdata[CTL_HALT]),
        .cont     (ctrl_q[CTL_CONT]),
        .wdata    (bus_wdata),
        .period   (period_q),
        .cnt_q    (cnt_q),
        .run_q    (run_q),
        .expire   (expire)
    );

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            case (idx)
                IDX_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, run_q, flag_q};
                IDX_CTRL:   bus_rdata = ctrl_q;
                IDX_PERIOD: bus_rdata = period_q;
                default:    bus_rdata = cnt_q;
            endcase
        end
    end

    assign irq = flag_q & ctrl_q[CTL_IE];
endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] cnt,
    input logic              run,
    input logic              flag,
    input logic              cont,
    input logic [DATA_W-1:0] period
);
    logic w_st, w_ctl, w_per, ends;
    assign w_st  = bus_wr && ((bus_addr >> 2) == 0);
    assign w_ctl = bus_wr && ((bus_addr >> 2) == 1);
    assign w_per = bus_wr && ((bus_addr >> 2) == 2);
    assign ends  = run && tick_en && (cnt <= 1);

    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (rst)
        w_per |=> cnt == $past(bus_wdata)); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !w_per) |=> $stable(cnt)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !w_st) |=> flag); // R3
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        ends |=> flag); // R11
    AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (ends && cont && !w_per && !w_ctl) |=> (run && cnt == $past(period))); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R10
endmodule

bind cdown_timer cdown_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .cnt       (cnt_q),
    .run       (run_q),
    .flag      (flag_q),
    .cont      (ctrl_q[1]),
    .period    (period_q)
);

// File: tb/cdown_timer_test.sv
module cdown_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0;
    int bad = 0;

    localparam logic [5:0] A_ST = 6'h00, A_CTL = 6'h04, A_PER = 6'h08, A_SNAP = 6'h0C;

    always #5 clk = ~clk;

    cdown_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(A_ST, v);   check("R1 status", v, 0);
        rd(A_CTL, v);  check("R1 ctrl", v, 0);
        rd(A_PER, v);  check("R1 period", v, 0);
        rd(A_SNAP, v); check("R1 snap", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R4 R2 control stores whole word, start+stop -> halted
        wr(A_CTL, 32'hA5A0_000E);
        rd(A_CTL, v); check("R4 ctrl readback", v, 32'hA5A0_000E);
        rd(A_ST, v);  check("R4 start+stop halted", v, 0);

        // R5 period load; R6 snapshot; R2 low address bits ignored
        wr(A_PER, 32'd7);
        rd(A_SNAP | 6'h3, v); check("R5 snapshot after load", v, 7);
        rd(A_PER, v);         check("R5 period stored", v, 7);
        wr(A_SNAP, 32'd99);
        rd(A_SNAP, v); check("R6 snapshot write ignored", v, 7);
        tick();
        rd(A_SNAP, v); check("R7 halted holds", v, 7);

        // R12 unmapped
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h18, v);  check("R12 unmapped read", v, 0);
        rd(A_CTL, v);  check("R12 ctrl untouched", v, 32'hA5A0_000E);
        rd(A_PER, v);  check("R12 period untouched", v, 7);

        // R8 R10 one-shot sweep with interrupt enabled
        for (int p = 1; p <= 4; p++) begin
            wr(A_PER, p);
            wr(A_CTL, 32'h5);
            @(negedge clk);
            rd(A_SNAP, v); check("R7 tick low holds", v, p);
            for (int t = 1; t <= p; t++) begin
                tick();
                rd(A_SNAP, v); check("R7 R8 count", v, (t == p) ? 0 : p - t);
                rd(A_ST, v);   check("R8 status", v, (t == p) ? 32'h1 : 32'h2);
                check("R10 irq", {31'b0, irq}, (t == p) ? 1 : 0);
            end
            tick();
            rd(A_SNAP, v); check("R8 stays 0 after one-shot", v, 0);
            wr(A_ST, 32'hDEAD_BEEF);
            rd(A_ST, v); check("R3 clear any data", v, 0);
            check("R10 irq after clear", {31'b0, irq}, 0);
        end

        // R10 flag without enable
        wr(A_PER, 1); wr(A_CTL, 32'h4); tick();
        rd(A_ST, v); check("R8 flag set", v, 1);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(A_CTL, 32'h1);
        check("R10 irq on enable", {31'b0, irq}, 1);
        wr(A_ST, 0);

        // R8 start from zero expires on next tick
        wr(A_PER, 0); wr(A_CTL, 32'h4);
        tick();
        rd(A_ST, v); check("R8 zero start expires", v, 1);
        wr(A_ST, 0);

        // R9 continuous sweep
        for (int p = 1; p <= 5; p++) begin
            wr(A_PER, p);
            wr(A_CTL, 32'h6);
            for (int t = 1; t <= 3 * p; t++) begin
                tick();
                rd(A_SNAP, v); check("R9 reload count", v, (t % p == 0) ? p : p - (t % p));
                rd(A_ST, v);   check("R9 running", v, {30'b0, 1'b1, (t >= p)});
            end
            wr(A_CTL, 32'h8);
            wr(A_ST, 0);
            rd(A_ST, v); check("R4 stop halts", v, 0);
        end

        // R5 retarget running counter
        wr(A_PER, 10); wr(A_CTL, 32'h4); tick(); tick();
        wr(A_PER, 3);
        rd(A_SNAP, v); check("R5 running reload", v, 3);
        tick();
        rd(A_SNAP, v); check("R7 after retarget", v, 2);

        // R11 expiry and status clear in same cycle
        tick();
        rd(A_SNAP, v); check("R11 setup", v, 1);
        bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'hFFFF_FFFF; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd(A_ST, v); check("R11 expiry wins", v, 1);
        wr(A_ST, 0);
        rd(A_ST, v); check("R3 later clear", v, 0);

        // R1 reset mid-run
        wr(A_PER, 5); wr(A_CTL, 32'h7);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        rd(A_ST, v);   check("R1 reset status", v, 0);
        rd(A_SNAP, v); check("R1 reset count", v, 0);
        rd(A_CTL, v);  check("R1 reset ctrl", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule